// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block produces the count-enable strobe that advances an 8-bit timer/counter. A 10-bit prescaler runs continuously off the system clock. It provides one-cycle tap strobes at every 8th, 64th, 256th and 1024th cycle. A 3-bit select input picks the source of the count-enable from these options:

- nothing (the timer is stopped),
- the undivided system clock,
- one of the four prescaler taps,
- a chosen edge of an external pin.

The external pin passes through a two-flop synchronizer and an edge register. An edge of the pin therefore becomes a single count-enable pulse a fixed number of cycles later.

The prescaler does not follow the select value. It is not cleared or paused when the source changes, so the first strobe after a switch depends on where the prescaler happens to be. A synchronous prescaler-clear input lets software restart the prescaler at a known instant, which aligns the taps to program flow. The count-enable output is registered, so it changes one clock edge after the source it follows.

Top module: `timer_tick_gen`

## Requirements
- R1: While `rst_n` is low, `count_en` is 0, and the prescaler and synchronizer are cleared.
- R2: With select code 0, `count_en` stays 0 whatever the pin and the prescaler do.
- R3: With select code 1, `count_en` is 1 in every cycle that follows an edge at which code 1 was sampled.
- R4: Select codes 2, 3, 4 and 5 choose divisors of 8, 64, 256 and 1024. `count_en` is then a one-cycle pulse repeating every N cycles. A tap fires when the low log2(N) bits of the prescaler are all ones.
- R5: The prescaler advances by one on every clock edge with `presc_clr` low, whatever the select value. Changing between taps keeps the prescaler phase.
- R6: An edge that samples `presc_clr` high sets the prescaler to 0 and produces no tap pulse. With divisor N, the first pulse then appears after the Nth following edge.
- R7: After a switch to a prescaled source with divisor N, the first pulse arrives between 1 and N+1 cycles later.
- R8: With select code 7, each rising edge of `ext_pin` gives exactly one `count_en` pulse. The pulse appears after the third clock edge following the pin change. This holds for a pin that stays stable for at least two cycles.
- R9: With select code 6, each falling edge of `ext_pin` gives exactly one pulse, with the same latency as in R8.
- R10: In the external modes, the pin edge of the other direction produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Count-enable source code (0..7) |
| presc_clr | input | 1 | Synchronous prescaler clear |
| ext_pin | input | 1 | Asynchronous external count pin |
| count_en | output | 1 | One-cycle count-enable strobe |

## Verification
A wrong prescaler phase moves every tap pulse. This shows at `count_en` within one divisor period after a clear, so every tap is checked at exact cycle offsets from a clear. A missing or extra synchronizer stage shifts the pin-driven pulse by a cycle, which the third-edge check catches at the first pin change. A swapped edge polarity shows as a pulse on the wrong pin transition in the very next pin sequence.

// File: rtl/tclk_pkg.sv
package tclk_pkg;
  localparam int PRE_W = 10;
  localparam int NTAP  = 4;

  typedef enum logic [2:0] {
    SRC_OFF   = 3'd0,
    SRC_SYS   = 3'd1,
    SRC_D8    = 3'd2,
    SRC_D64   = 3'd3,
    SRC_D256  = 3'd4,
    SRC_D1024 = 3'd5,
    SRC_PFALL = 3'd6,
    SRC_PRISE = 3'd7
  } src_sel_e;

  // number of low prescaler bits that must be ones for tap idx
  function automatic int tap_bits(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  // true when the low nb bits of c are all ones
  function automatic logic low_ones(input logic [PRE_W-1:0] c, input int nb);
    logic r;
    r = 1'b1;
    for (int j = 0; j < PRE_W; j++)
      if (j < nb && !c[j]) r = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tclk_pkg::*;
#(
  parameter int W  = PRE_W,
  parameter int NT = NTAP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [NT-1:0] tap_stb
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  generate
    for (genvar t = 0; t < NT; t++) begin : g_tap
      assign tap_stb[t] = !clr && low_ones(cnt, tap_bits(t));
    end
  endgenerate

  // R5
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr)) |-> cnt == $past(cnt) + 1'b1);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

  // R4
  tap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_stb[0] |=> !tap_stb[0]);
endmodule

// File: rtl/pin_edge_sync.sv
module pin_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 && !s3;
  assign fall = !s2 && s3;

  // R10
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !fall);
endmodule

// File: rtl/tick_select.sv
module tick_select
  import tclk_pkg::*;
#(
  parameter int NT = NTAP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    sel,
  input  logic [NT-1:0] taps,
  input  logic          rise,
  input  logic          fall,
  output logic          tick
);
  src_sel_e src;
  logic     nxt;

  assign src = src_sel_e'(sel);

  always_comb begin
    case (src)
      SRC_OFF:   nxt = 1'b0;
      SRC_SYS:   nxt = 1'b1;
      SRC_D8:    nxt = taps[0];
      SRC_D64:   nxt = taps[1];
      SRC_D256:  nxt = taps[2];
      SRC_D1024: nxt = taps[NT-1];
      SRC_PFALL: nxt = fall;
      SRC_PRISE: nxt = rise;
      default:   nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= nxt;
  end

  // R2
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel) == 3'd0) |-> !tick);

  // R3
  sys_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel) == 3'd1) |-> tick);
endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import tclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  input  logic       presc_clr,
  input  logic       ext_pin,
  output logic       count_en
);
  logic [NTAP-1:0] tap_stb;
  logic            pin_rise, pin_fall;

  tick_prescaler #(.W(PRE_W), .NT(NTAP)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(presc_clr), .tap_stb(tap_stb)
  );

  pin_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(pin_rise), .fall(pin_fall)
  );

  tick_select #(.NT(NTAP)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel(clk_sel), .taps(tap_stb),
    .rise(pin_rise), .fall(pin_fall), .tick(count_en)
  );

  // R8
  ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(clk_sel) == 3'd7 &&
     $past(clk_sel, 2) == 3'd7 && $past(count_en)) |-> !count_en);

  // R1
  reset_low_chk: assert property (@(posedge clk) !rst_n |-> !count_en);
endmodule

// File: tb/sim_timer_tick_gen.sv
module sim_timer_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic       presc_clr = 1'b0;
  logic       ext_pin = 1'b0;
  logic       count_en;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  timer_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .presc_clr(presc_clr),
    .ext_pin(ext_pin), .count_en(count_en)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    // R1
    chk(count_en == 1'b0, "R1 reset output", count_en, 0);
    repeat (3) step();
    chk(count_en == 1'b0, "R1 held in reset", count_en, 0);
    rst_n = 1'b1;
    step();
    chk(count_en == 1'b0, "R1 after release", count_en, 0);
  endtask

  task automatic t_stop();
    int hits = 0;
    clk_sel = 3'd0;
    for (int i = 0; i < 300; i++) begin
      ext_pin = (i % 6) < 3;
      step();
      if (count_en) hits++;
    end
    ext_pin = 1'b0;
    chk(hits == 0, "R2 stopped", hits, 0);
  endtask

  task automatic t_sys();
    int hits = 0;
    clk_sel = 3'd1;
    for (int i = 0; i < 20; i++) begin
      step();
      if (count_en) hits++;
    end
    chk(hits == 20, "R3 every cycle", hits, 20);
    clk_sel = 3'd0;
    step();
  endtask

  task automatic t_taps();
    for (int k = 0; k < 4; k++) begin
      int n = (k == 0) ? 8 : (k == 1) ? 64 : (k == 2) ? 256 : 1024;
      int bad = 0;
      int hits = 0;
      clk_sel = 3'(2 + k);
      presc_clr = 1'b1;
      step();
      // R6: the clearing edge itself produces no pulse
      chk(count_en == 1'b0, "R6 no pulse on clear", count_en, 0);
      presc_clr = 1'b0;
      for (int i = 1; i <= 2 * n + 1; i++) begin
        step();
        if (count_en) hits++;
        if (count_en != ((i % n) == 0)) bad++;
      end
      // R4 and R6: pulses exactly at N and 2N after the clear
      chk(bad == 0, "R4 tap period", bad, 0);
      chk(hits == 2, "R4 pulse count", hits, 2);
    end
  endtask

  task automatic t_clear_hold();
    int hits = 0;
    clk_sel = 3'd2;
    presc_clr = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      if (count_en) hits++;
    end
    presc_clr = 1'b0;
    chk(hits == 0, "R6 clear held", hits, 0);
  endtask

  task automatic t_phase_keep();
    int bad = 0;
    clk_sel = 3'd2;
    presc_clr = 1'b1;
    step();
    presc_clr = 1'b0;
    for (int i = 1; i <= 70; i++) begin
      step();
      if (count_en != ((i <= 10) ? ((i % 8) == 0) : ((i % 64) == 0))) bad++;
      if (i == 10) clk_sel = 3'd3;
    end
    // R5: a tap switch keeps the prescaler phase
    chk(bad == 0, "R5 phase kept", bad, 0);
  endtask

  task automatic t_latency();
    for (int p = 0; p < 3; p++) begin
      int lat = 0;
      clk_sel = 3'd0;
      repeat ((p == 0) ? 5 : (p == 1) ? 77 : 200) step();
      clk_sel = 3'd4;
      for (int i = 1; i <= 300; i++) begin
        step();
        if (count_en && lat == 0) lat = i;
      end
      // R7
      chk(lat >= 1 && lat <= 257, "R7 first pulse latency", lat, 257);
    end
    clk_sel = 3'd0;
  endtask

  task automatic t_ext(input bit rising);
    string rq = rising ? "R8" : "R9";
    clk_sel = rising ? 3'd7 : 3'd6;
    ext_pin = rising ? 1'b0 : 1'b1;
    repeat (8) step();
    for (int r = 0; r < 2; r++) begin
      int bad = 0;
      int extra = 0;
      ext_pin = ~ext_pin;
      for (int i = 1; i <= 5; i++) begin
        step();
        if (count_en != (i == 3)) bad++;
      end
      chk(bad == 0, rq, bad, 0);
      ext_pin = ~ext_pin;
      for (int i = 1; i <= 6; i++) begin
        step();
        if (count_en) extra++;
      end
      // R10: the opposite edge is ignored
      chk(extra == 0, "R10 opposite edge", extra, 0);
    end
    clk_sel = 3'd0;
    ext_pin = 1'b0;
    repeat (4) step();
  endtask

  initial begin
    t_reset();
    t_stop();
    t_sys();
    t_taps();
    t_clear_hold();
    t_phase_keep();
    t_latency();
    t_ext(1'b1);
    t_ext(1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule